// File: doc/BRIEF.md
# Dual Down-Counter Timer with Interrupt Summary

This peripheral holds two 16-bit down-counters and a seven-bit pending/enable interrupt pair behind a small byte-wide register bus. A host reaches it through a 4-bit offset, 8-bit write and read data, and single-cycle write and read strobes. Read data is combinational from the offset while the read strobe is high. The side effects of a read take place at the clock edge that ends the strobe cycle.

The first counter arms and loads only when its upper byte is written. It can run as a one-shot or reload itself from its latches on every wrap, and it drives a square-wave pin that toggles on each wrap in reload mode. The second counter is one-shot only. A mode byte supplied on an input port selects the reload mode of the first counter and can freeze the second. Five more interrupt sources, such as a shift unit and handshake lines, raise their pending bits through a set input. One request line reports whether any enabled pending bit is set.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset, counters, latches, pending bits and enables are zero, the square-wave pin is high and the request line is low. Offset 14 reads 0x80 and all other offsets read 0x00.
- R2: Writes to offset 4 or 6 change only the low latch of counter 1. A write to offset 7 changes only its high latch and leaves the counter value unchanged. Offsets 6 and 7 read back the low and high latches.
- R3: A write to offset 5 stores the high latch, loads counter 1 with {data, low latch}, clears pending bit 6, starts and arms counter 1, and drives the square-wave pin low.
- R4: While running, counter 1 decrements once per cycle. With mode bit 6 set, the cycle at which it passes from 0 sets pending bit 6, toggles the pin and reloads {high latch, low latch}, so a value N repeats every N+1 cycles.
- R5: With mode bit 6 clear, the first wrap after arming sets pending bit 6 and drives the pin high. It then disarms, so later wraps set nothing.
- R6: A write to offset 8 stores the low latch of counter 2. A write to offset 9 loads {data, low latch}, clears pending bit 5 and arms the counter. The wrap from 0 sets pending bit 5 once.
- R7: Counter 2 holds its value while mode bit 5 is set.
- R8: A read of offset 4 (or 8) returns the low counter byte, clears pending bit 6 (or 5), and stops and disarms that counter. Offsets 5 and 9 return the high counter bytes with no side effect.
- R9: Writing offset 13 clears each pending bit 6:0 whose data bit is 1. A one-cycle pulse on bit i of the external set input sets pending bit i (i = 0..4).
- R10: A write to offset 14 with data bit 7 set sets the enables selected by data bits 6:0. With data bit 7 clear, it clears them. Reading offset 14 returns the enables with bit 7 forced to 1.
- R11: The request line is high exactly when some pending bit 6:0 is set together with its enable. Reading offset 13 returns that request state in bit 7 above the pending bits.
- R12: A bit that is set and cleared in the same cycle ends set. A register load in the same cycle as a count takes the loaded value.
- R13: Offset 11 reads back the mode byte input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| mode_ctrl | input | 8 | Mode byte: bit 6 reload mode of counter 1, bit 5 freezes counter 2 |
| ext_flag_set | input | 5 | Set pulses for pending bits 4:0 |
| irq | output | 1 | Interrupt request |
| t1_wave | output | 1 | Square-wave pin of counter 1 |

## Verification
Read data is due in the same cycle as the read strobe. Every register effect of a write or read, including the request line and the pin level, is visible one edge later. A counter loaded with N reaches 0 N cycles after the load edge and produces its wrap event at edge N+1. The bench drives every strobe at a falling edge and lets the scoreboard sample read data 2 ns after it. It counts idle cycles from the falling edge that follows the load, so every expected value, such as a pending bit absent at cycle N and present at cycle N+1, sits on a known cycle.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam logic [3:0] OFS_T1_CNT_LO = 4'd4;
  localparam logic [3:0] OFS_T1_CNT_HI = 4'd5;
  localparam logic [3:0] OFS_T1_LAT_LO = 4'd6;
  localparam logic [3:0] OFS_T1_LAT_HI = 4'd7;
  localparam logic [3:0] OFS_T2_CNT_LO = 4'd8;
  localparam logic [3:0] OFS_T2_CNT_HI = 4'd9;
  localparam logic [3:0] OFS_MODE      = 4'd11;
  localparam logic [3:0] OFS_PEND      = 4'd13;
  localparam logic [3:0] OFS_ENAB      = 4'd14;

  localparam int PEND_T1   = 6;
  localparam int PEND_T2   = 5;
  localparam int MODE_T1RL = 6;
  localparam int MODE_T2HD = 5;

  typedef struct packed {
    logic t1_lo_lat_wr;
    logic t1_hi_lat_wr;
    logic t1_load_wr;
    logic t2_lo_lat_wr;
    logic t2_load_wr;
    logic pend_wr;
    logic enab_wr;
    logic t1_lo_rd;
    logic t2_lo_rd;
  } dtmr_strobe_t;

endpackage

// File: rtl/dtmr_busdec.sv
module dtmr_busdec
  import dtmr_pkg::*;
(
  input  logic [3:0]   addr,
  input  logic         wr,
  input  logic         rd,
  output dtmr_strobe_t stb
);

  function automatic logic hit(input logic [3:0] a, input logic [3:0] ofs);
    return a == ofs;
  endfunction

  always_comb begin
    stb.t1_lo_lat_wr = wr && (hit(addr, OFS_T1_CNT_LO) || hit(addr, OFS_T1_LAT_LO));
    stb.t1_hi_lat_wr = wr && hit(addr, OFS_T1_LAT_HI);
    stb.t1_load_wr   = wr && hit(addr, OFS_T1_CNT_HI);
    stb.t2_lo_lat_wr = wr && hit(addr, OFS_T2_CNT_LO);
    stb.t2_load_wr   = wr && hit(addr, OFS_T2_CNT_HI);
    stb.pend_wr      = wr && hit(addr, OFS_PEND);
    stb.enab_wr      = wr && hit(addr, OFS_ENAB);
    stb.t1_lo_rd     = rd && hit(addr, OFS_T1_CNT_LO);
    stb.t2_lo_rd     = rd && hit(addr, OFS_T2_CNT_LO);
  end

endmodule

// File: rtl/dtmr_t1.sv
module dtmr_t1 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_lat_wr,
  input  logic          hi_lat_wr,
  input  logic          load_wr,
  input  logic          lo_rd,
  input  logic [DW-1:0] wdata,
  input  logic          reload_mode,
  output logic [2*DW-1:0] cnt,
  output logic [DW-1:0] lat_lo,
  output logic [DW-1:0] lat_hi,
  output logic          wrap_evt,
  output logic          pend_set,
  output logic          wave
);

  localparam int CW = 2 * DW;

  logic run;
  logic armed;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic [CW-1:0] join_bytes(input logic [DW-1:0] hi, input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction

  assign wrap_evt = run && !load_wr && (cnt == '0);
  assign pend_set = wrap_evt && (reload_mode || armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      lat_lo <= '0;
      lat_hi <= '0;
      run    <= 1'b0;
      armed  <= 1'b0;
      wave   <= 1'b1;
    end else begin
      if (lo_lat_wr) lat_lo <= wdata;
      if (hi_lat_wr || load_wr) lat_hi <= wdata;
      if (load_wr) begin
        cnt   <= join_bytes(wdata, lat_lo);
        run   <= 1'b1;
        armed <= 1'b1;
        wave  <= 1'b0;
      end else begin
        if (run) begin
          if (wrap_evt && reload_mode) cnt <= join_bytes(lat_hi, lat_lo);
          else                         cnt <= next_count(cnt);
        end
        if (wrap_evt) begin
          if (reload_mode) begin
            wave <= ~wave;
          end else if (armed) begin
            wave  <= 1'b1;
            armed <= 1'b0;
          end
        end
        if (lo_rd) begin
          run   <= 1'b0;
          armed <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dtmr_t2.sv
module dtmr_t2 #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_lat_wr,
  input  logic            load_wr,
  input  logic            lo_rd,
  input  logic [DW-1:0]   wdata,
  input  logic            hold,
  output logic [2*DW-1:0] cnt,
  output logic            pend_set
);

  localparam int CW = 2 * DW;

  logic [DW-1:0] lat_lo;
  logic          run;
  logic          armed;
  logic          step;
  logic          wrap_evt;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c);
    return c - 1'b1;
  endfunction

  assign step     = run && !hold && !load_wr;
  assign wrap_evt = step && (cnt == '0);
  assign pend_set = wrap_evt && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      lat_lo <= '0;
      run    <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (lo_lat_wr) lat_lo <= wdata;
      if (load_wr) begin
        cnt   <= {wdata, lat_lo};
        run   <= 1'b1;
        armed <= 1'b1;
      end else begin
        if (step) cnt <= next_count(cnt);
        if (wrap_evt) armed <= 1'b0;
        if (lo_rd) begin
          run   <= 1'b0;
          armed <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dtmr_intctl.sv
module dtmr_intctl #(
  parameter int NS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_vec,
  input  logic [NS-1:0] clr_vec,
  input  logic          enab_wr,
  input  logic          enab_pol,
  input  logic [NS-1:0] enab_sel,
  output logic [NS-1:0] pend,
  output logic [NS-1:0] enab,
  output logic          req
);

  function automatic logic summary(input logic [NS-1:0] p, input logic [NS-1:0] e);
    return |(p & e);
  endfunction

  function automatic logic [NS-1:0] pend_next(input logic [NS-1:0] p,
                                              input logic [NS-1:0] s,
                                              input logic [NS-1:0] c);
    return (p & ~c) | s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      enab <= '0;
    end else begin
      pend <= pend_next(pend, set_vec, clr_vec);
      if (enab_wr) begin
        if (enab_pol) enab <= enab | enab_sel;
        else          enab <= enab & ~enab_sel;
      end
    end
  end

  assign req = summary(pend, enab);

endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dtmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] mode_ctrl,
  input  logic [DW-4:0] ext_flag_set,
  output logic          irq,
  output logic          t1_wave
);

  localparam int NS = DW - 1;
  localparam int CW = 2 * DW;

  dtmr_strobe_t  stb;
  logic [CW-1:0] t1_cnt;
  logic [DW-1:0] t1_lat_lo;
  logic [DW-1:0] t1_lat_hi;
  logic          t1_wrap;
  logic          t1_pset;
  logic [CW-1:0] t2_cnt;
  logic          t2_pset;
  logic [NS-1:0] set_vec;
  logic [NS-1:0] clr_vec;
  logic [NS-1:0] pend;
  logic [NS-1:0] enab;

  dtmr_busdec u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .stb  (stb)
  );

  dtmr_t1 #(.DW(DW)) u_t1 (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_lat_wr   (stb.t1_lo_lat_wr),
    .hi_lat_wr   (stb.t1_hi_lat_wr),
    .load_wr     (stb.t1_load_wr),
    .lo_rd       (stb.t1_lo_rd),
    .wdata       (bus_wdata),
    .reload_mode (mode_ctrl[MODE_T1RL]),
    .cnt         (t1_cnt),
    .lat_lo      (t1_lat_lo),
    .lat_hi      (t1_lat_hi),
    .wrap_evt    (t1_wrap),
    .pend_set    (t1_pset),
    .wave        (t1_wave)
  );

  dtmr_t2 #(.DW(DW)) u_t2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_lat_wr (stb.t2_lo_lat_wr),
    .load_wr   (stb.t2_load_wr),
    .lo_rd     (stb.t2_lo_rd),
    .wdata     (bus_wdata),
    .hold      (mode_ctrl[MODE_T2HD]),
    .cnt       (t2_cnt),
    .pend_set  (t2_pset)
  );

  always_comb begin
    set_vec = '0;
    set_vec[DW-4:0]  = ext_flag_set;
    set_vec[PEND_T1] = t1_pset;
    set_vec[PEND_T2] = t2_pset;
    clr_vec = stb.pend_wr ? bus_wdata[NS-1:0] : '0;
    if (stb.t1_load_wr || stb.t1_lo_rd) clr_vec[PEND_T1] = 1'b1;
    if (stb.t2_load_wr || stb.t2_lo_rd) clr_vec[PEND_T2] = 1'b1;
  end

  dtmr_intctl #(.NS(NS)) u_int (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .enab_wr  (stb.enab_wr),
    .enab_pol (bus_wdata[DW-1]),
    .enab_sel (bus_wdata[NS-1:0]),
    .pend     (pend),
    .enab     (enab),
    .req      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_T1_CNT_LO: bus_rdata = t1_cnt[DW-1:0];
        OFS_T1_CNT_HI: bus_rdata = t1_cnt[CW-1:DW];
        OFS_T1_LAT_LO: bus_rdata = t1_lat_lo;
        OFS_T1_LAT_HI: bus_rdata = t1_lat_hi;
        OFS_T2_CNT_LO: bus_rdata = t2_cnt[DW-1:0];
        OFS_T2_CNT_HI: bus_rdata = t2_cnt[CW-1:DW];
        OFS_MODE:      bus_rdata = mode_ctrl;
        OFS_PEND:      bus_rdata = {irq, pend};
        OFS_ENAB:      bus_rdata = {1'b1, enab};
        default:       bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [DW-1:0]   bus_rdata,
  input logic [DW-1:0]   mode_ctrl,
  input logic            irq,
  input logic            t1_wave,
  input logic [2*DW-1:0] t1_cnt,
  input logic [DW-1:0]   t1_lat_lo,
  input logic            t1_wrap,
  input logic            t1_pset,
  input logic [2*DW-1:0] t2_cnt,
  input logic [DW-2:0]   pend
);

  assert_t1_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd5) |=> (t1_cnt == $past({bus_wdata, t1_lat_lo}) && !t1_wave));

  assert_t1_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    t1_pset |=> pend[6]);

  assert_t1_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_wrap && mode_ctrl[6]) |=> (t1_wave != $past(t1_wave)));

  assert_t2_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd && mode_ctrl[5]) |=> $stable(t2_cnt));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd13 && bus_wdata[6] && !t1_pset) |=> !pend[6]);

  assert_enab_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'd14) |-> bus_rdata[DW-1]);

  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd14 && bus_wdata[DW-1] && (|(bus_wdata[DW-2:0] & pend))) |=> irq);

endmodule

bind dual_timer_irq dtmr_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .mode_ctrl (mode_ctrl),
  .irq       (irq),
  .t1_wave   (t1_wave),
  .t1_cnt    (t1_cnt),
  .t1_lat_lo (t1_lat_lo),
  .t1_wrap   (t1_wrap),
  .t1_pset   (t1_pset),
  .t2_cnt    (t2_cnt),
  .pend      (pend)
);

// File: tb/dual_timer_irq_tb.sv
module dual_timer_irq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] mode_ctrl = '0;
  logic [4:0] ext_flag_set = '0;
  logic       irq;
  logic       t1_wave;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  dual_timer_irq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .mode_ctrl    (mode_ctrl),
    .ext_flag_set (ext_flag_set),
    .irq          (irq),
    .t1_wave      (t1_wave)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every read strobe, 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (bus_rd && exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk({7'd0, t1_wave}, 8'h01, "R1 wave high");
    chk({7'd0, irq}, 8'h00, "R1 irq low");
    rd(4'd13, 8'h00, "R1 pend");
    rd(4'd14, 8'h80, "R1 enab");
    rd(4'd5, 8'h00, "R1 t1 hi");
    rd(4'd6, 8'h00, "R1 t1 lat lo");
    rd(4'd7, 8'h00, "R1 t1 lat hi");
    rd(4'd9, 8'h00, "R1 t2 hi");
    rd(4'd8, 8'h00, "R1 t2 lo");

    // R13 mode readback
    mode_ctrl = 8'h9A;
    rd(4'd11, 8'h9A, "R13 mode");
    mode_ctrl = 8'h40;

    // R3/R4 reload mode, value 5
    wr(4'd4, 8'h05);
    wr(4'd5, 8'h00);
    chk({7'd0, t1_wave}, 8'h00, "R3 wave low after load");
    idle(5);
    rd(4'd13, 8'h00, "R4 no pend at count 0");
    chk({7'd0, t1_wave}, 8'h01, "R4 wave toggled");
    rd(4'd13, 8'h40, "R4 pend after wrap");
    idle(5);
    chk({7'd0, t1_wave}, 8'h00, "R4 second toggle after N+1");
    rd(4'd4, 8'h05, "R4 reloaded value / R8 low read");
    rd(4'd13, 8'h00, "R8 read clears pend 6");
    rd(4'd4, 8'h04, "R8 counter stopped");
    rd(4'd5, 8'h00, "R8 high byte");

    // R2 latch writes
    wr(4'd6, 8'h11);
    rd(4'd6, 8'h11, "R2 low latch via 6");
    wr(4'd7, 8'h22);
    rd(4'd7, 8'h22, "R2 high latch");
    rd(4'd5, 8'h00, "R2 offset 7 no load hi");
    rd(4'd4, 8'h04, "R2 offset 7 no load lo");
    wr(4'd4, 8'h33);
    rd(4'd6, 8'h33, "R2 low latch via 4");
    rd(4'd7, 8'h22, "R2 offset 4 keeps high latch");

    // R5 one-shot
    mode_ctrl = 8'h00;
    wr(4'd4, 8'h03);
    wr(4'd5, 8'h00);
    idle(3);
    rd(4'd13, 8'h00, "R5 no pend yet");
    chk({7'd0, t1_wave}, 8'h01, "R5 wave high at wrap");
    rd(4'd13, 8'h40, "R5 pend set");

    // R10/R11 enable and request
    wr(4'd14, 8'hC0);
    chk({7'd0, irq}, 8'h01, "R11 irq up");
    rd(4'd14, 8'hC0, "R10 enab set");
    rd(4'd13, 8'hC0, "R11 summary bit");
    wr(4'd14, 8'h40);
    chk({7'd0, irq}, 8'h00, "R11 irq down");
    rd(4'd14, 8'h80, "R10 enab clear");
    wr(4'd13, 8'h40);
    idle(20);
    rd(4'd13, 8'h00, "R5 no second pend");
    chk({7'd0, t1_wave}, 8'h01, "R5 wave stays high");

    // R6 counter 2 one-shot
    wr(4'd8, 8'h02);
    wr(4'd9, 8'h00);
    idle(2);
    rd(4'd13, 8'h00, "R6 no pend at 0");
    rd(4'd13, 8'h20, "R6 pend after wrap");
    rd(4'd8, 8'hFE, "R6 counts past wrap / R8");
    rd(4'd13, 8'h00, "R8 read clears pend 5");

    // R7 hold
    mode_ctrl = 8'h20;
    wr(4'd8, 8'h07);
    wr(4'd9, 8'h01);
    idle(10);
    rd(4'd9, 8'h01, "R7 held hi");
    rd(4'd8, 8'h07, "R7 held lo");
    mode_ctrl = 8'h00;

    // R9 external set and write-one-clear
    ext_flag_set = 5'b00100;
    idle(1);
    ext_flag_set = 5'b00000;
    rd(4'd13, 8'h04, "R9 ext set bit 2");
    wr(4'd13, 8'h04);
    rd(4'd13, 8'h00, "R9 cleared");

    // R12 set beats clear
    ext_flag_set = 5'b00001;
    wr(4'd13, 8'h01);
    ext_flag_set = 5'b00000;
    rd(4'd13, 8'h01, "R12 set wins");
    wr(4'd13, 8'h01);
    rd(4'd13, 8'h00, "R12 later clear");

    idle(2);
    done = 1'b1;
    report();
  end

endmodule